// File: doc/BRIEF.md
# Dual-Lane Complex Fractional Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate engine for packed 16-bit signal data. Each 32-bit operand holds two signed halfwords: the upper halfword in bits 31:16 and the lower one in bits 15:0. Every issued operation runs two signed 16x16 multiplies at once. It then combines the two products by one of four modes and adds the combined value into one of four 64-bit accumulators. A complex multiply-accumulate takes two issues. One uses the subtracting mode for the real part. The other uses the cross mode for the imaginary part, and that mode pairs each upper lane with the opposite lower lane, so the operand never has to be swapped first.

Products can be taken as plain integers or as Q15 fractions. A fraction product is doubled, and the single case that cannot be represented saturates and raises a sticky per-accumulator flag. A new operation can be issued every cycle. A result that is still in flight is forwarded to a following operation on the same accumulator. A host port loads or clears any accumulator. A read port returns any accumulator and has no cycle of latency.

Top module: `cplx_mac`

## Requirements
- R1: After reset all four accumulators read zero and `ovf` is 0. A host write with `wr_en`=1 loads `wr_data` into accumulator `wr_sel` on that clock edge. `rd_data` shows accumulator `rd_sel` combinationally.
- R2: Mode 0 (dot) adds a.hi*b.hi + a.lo*b.lo to the selected accumulator. Here hi is bits 31:16 and lo is bits 15:0, both signed.
- R3: Mode 1 (real part) adds a.hi*b.hi - a.lo*b.lo to the selected accumulator.
- R4: Mode 2 (cross) adds a.hi*b.lo + a.lo*b.hi to the selected accumulator.
- R5: Mode 3 (negated dot) subtracts a.hi*b.hi + a.lo*b.lo from the selected accumulator.
- R6: With `frac`=1 each product is doubled. 0x8000 times 0x8000 gives 0x7FFFFFFF and sets bit `acc_sel` of `ovf`. The flag stays set until a host write to that accumulator clears it. With `frac`=0 the same inputs give 0x40000000 and the flag stays clear.
- R7: If an operation is sampled at clock edge k, `rd_data` shows its result after edge k+2 and not before.
- R8: Operations may be issued on consecutive cycles to the same accumulator, and every one of them is accumulated.
- R9: The 64-bit accumulation wraps in two's complement and does not saturate.
- R10: A host write at edge e overrides an operation whose write-back also falls at edge e. That is an operation issued at e-2, and its flag is dropped too. An operation issued at e-1 adds onto the written value.
- R11: While `issue_valid` is 0, the operand, mode and select inputs change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Issue an operation this cycle |
| op_a | input | 32 | First packed operand (hi, lo halfwords) |
| op_b | input | 32 | Second packed operand (hi, lo halfwords) |
| acc_sel | input | 2 | Target accumulator of the operation |
| mode | input | 2 | 0 dot, 1 real part, 2 cross, 3 negated dot |
| frac | input | 1 | 1 selects Q15 fractional products |
| wr_en | input | 1 | Host accumulator write |
| wr_sel | input | 2 | Accumulator written by the host |
| wr_data | input | 64 | Host write value |
| rd_sel | input | 2 | Accumulator shown on rd_data |
| rd_data | output | 64 | Selected accumulator value |
| ovf | output | 4 | Sticky fractional saturation flag per accumulator |

## Verification
The bench builds the block with its default parameters: 16-bit lanes, 64-bit accumulators and four of them. At these widths the only saturating fraction product, the most negative halfword squared, can be reached directly. Preloading an accumulator to its largest positive value makes the 64-bit wrap reachable with a single issue. With four accumulators, interleaved and back-to-back issues exercise both the in-flight forwarding path and the collision between host writes and write-back.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [1:0] {
    MODE_DOT   = 2'd0,
    MODE_REAL  = 2'd1,
    MODE_CROSS = 2'd2,
    MODE_NDOT  = 2'd3
  } cmac_mode_e;
endpackage

// File: rtl/cmac_lane_mul.sv
module cmac_lane_mul #(
  parameter int LANE_W = 16
) (
  input  logic signed [LANE_W-1:0]   x_i,
  input  logic signed [LANE_W-1:0]   y_i,
  input  logic                       frac_i,
  output logic        [2*LANE_W-1:0] prod_o,
  output logic                       sat_o
);
  localparam int PROD_W = 2 * LANE_W;
  localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};

  logic signed [PROD_W-1:0] full;

  always_comb begin
    full   = x_i * y_i;
    sat_o  = 1'b0;
    prod_o = full;
    if (frac_i) begin
      if (x_i == MOST_NEG && y_i == MOST_NEG) begin
        prod_o = {1'b0, {(PROD_W-1){1'b1}}};
        sat_o  = 1'b1;
      end else begin
        prod_o = full <<< 1;
      end
    end
  end
endmodule

// File: rtl/cmac_acc_bank.sv
module cmac_acc_bank #(
  parameter int ACC_W = 64,
  parameter int N_ACC = 4,
  localparam int IDX_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_v_i,
  input  logic [IDX_W-1:0] wb_sel_i,
  input  logic [ACC_W-1:0] wb_data_i,
  input  logic             wb_sat_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_sel_i,
  input  logic [IDX_W-1:0] fw_sel_i,
  output logic [ACC_W-1:0] rd_data_o,
  output logic [ACC_W-1:0] fw_data_o,
  output logic [N_ACC-1:0] ovf_o
);
  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] acc_d [N_ACC];
  logic [N_ACC-1:0] acc_en;
  logic [N_ACC-1:0] ovf_q, ovf_d;

  // Write-back first, host write after it: the host wins a same-edge collision.
  always_comb begin
    ovf_d = ovf_q;
    for (int i = 0; i < N_ACC; i++) begin
      acc_d[i]  = acc_q[i];
      acc_en[i] = 1'b0;
      if (wb_v_i && wb_sel_i == IDX_W'(i)) begin
        acc_d[i]  = wb_data_i;
        acc_en[i] = 1'b1;
        if (wb_sat_i) ovf_d[i] = 1'b1;
      end
      if (wr_en_i && wr_sel_i == IDX_W'(i)) begin
        acc_d[i]  = wr_data_i;
        acc_en[i] = 1'b1;
        ovf_d[i]  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
      ovf_q <= '0;
    end else begin
      for (int i = 0; i < N_ACC; i++) begin
        if (acc_en[i]) acc_q[i] <= acc_d[i];
      end
      ovf_q <= ovf_d;
    end
  end

  assign rd_data_o = acc_q[rd_sel_i];
  assign fw_data_o = acc_q[fw_sel_i];
  assign ovf_o     = ovf_q;

  for (genvar g = 0; g < N_ACC; g++) begin : g_chk
    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[g]) |-> $past(wb_v_i && wb_sat_i && wb_sel_i == IDX_W'(g)));
    // R1
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == IDX_W'(g)) |=> (acc_q[g] == $past(wr_data_i)) && !ovf_q[g]);
    // R11
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en_i && wr_sel_i == IDX_W'(g)) && !(wb_v_i && wb_sel_i == IDX_W'(g)))
      |=> $stable(acc_q[g]));
  end
endmodule

// File: rtl/cplx_mac.sv
module cplx_mac
  import cmac_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int ACC_W  = 64,
  parameter int N_ACC  = 4,
  localparam int OP_W   = 2 * LANE_W,
  localparam int PROD_W = 2 * LANE_W,
  localparam int IDX_W  = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [IDX_W-1:0] acc_sel,
  input  logic [1:0]       mode,
  input  logic             frac,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_sel,
  output logic [ACC_W-1:0] rd_data,
  output logic [N_ACC-1:0] ovf
);
  // Stage 0: lane pairing and the two multipliers
  cmac_mode_e                   mode_in;
  logic [1:0][LANE_W-1:0]       mx, my;
  logic [1:0][PROD_W-1:0]       m_prod;
  logic [1:0]                   m_sat;

  assign mode_in = cmac_mode_e'(mode);

  always_comb begin
    mx[0] = op_a[OP_W-1:LANE_W];
    mx[1] = op_a[LANE_W-1:0];
    if (mode_in == MODE_CROSS) begin
      my[0] = op_b[LANE_W-1:0];
      my[1] = op_b[OP_W-1:LANE_W];
    end else begin
      my[0] = op_b[OP_W-1:LANE_W];
      my[1] = op_b[LANE_W-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    cmac_lane_mul #(.LANE_W(LANE_W)) u_mul (
      .x_i    (mx[g]),
      .y_i    (my[g]),
      .frac_i (frac),
      .prod_o (m_prod[g]),
      .sat_o  (m_sat[g])
    );
  end

  // Stage 1 registers: products
  logic                   s1_v;
  logic [IDX_W-1:0]       s1_sel;
  cmac_mode_e             s1_mode;
  logic [1:0][PROD_W-1:0] s1_prod;
  logic [1:0]             s1_sat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_sel  <= '0;
      s1_mode <= MODE_DOT;
      s1_prod <= '0;
      s1_sat  <= '0;
    end else begin
      s1_v <= issue_valid;
      if (issue_valid) begin
        s1_sel  <= acc_sel;
        s1_mode <= mode_in;
        s1_prod <= m_prod;
        s1_sat  <= m_sat;
      end
    end
  end

  // Stage 2: combine products, add onto the forwarded accumulator value
  logic                    s2_v;
  logic [IDX_W-1:0]        s2_sel;
  logic [ACC_W-1:0]        s2_res;
  logic                    s2_sat;
  logic [ACC_W-1:0]        bank_fw;
  logic signed [ACC_W-1:0] p0, p1, term, base, res_d;

  always_comb begin
    p0 = {{(ACC_W-PROD_W){s1_prod[0][PROD_W-1]}}, s1_prod[0]};
    p1 = {{(ACC_W-PROD_W){s1_prod[1][PROD_W-1]}}, s1_prod[1]};
    unique case (s1_mode)
      MODE_DOT:   term = p0 + p1;
      MODE_REAL:  term = p0 - p1;
      MODE_CROSS: term = p0 + p1;
      MODE_NDOT:  term = -(p0 + p1);
      default:    term = p0 + p1;
    endcase
    if (wr_en && wr_sel == s1_sel)
      base = wr_data;
    else if (s2_v && s2_sel == s1_sel)
      base = s2_res;
    else
      base = bank_fw;
    res_d = base + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v   <= 1'b0;
      s2_sel <= '0;
      s2_res <= '0;
      s2_sat <= 1'b0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_sel <= s1_sel;
        s2_res <= res_d;
        s2_sat <= |s1_sat;
      end
    end
  end

  // Stage 3: write-back into the accumulator bank
  cmac_acc_bank #(.ACC_W(ACC_W), .N_ACC(N_ACC)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_v_i    (s2_v),
    .wb_sel_i  (s2_sel),
    .wb_data_i (s2_res),
    .wb_sat_i  (s2_sat),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .rd_sel_i  (rd_sel),
    .fw_sel_i  (s1_sel),
    .rd_data_o (rd_data),
    .fw_data_o (bank_fw),
    .ovf_o     (ovf)
  );

  // R7
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> ##1 s2_v);

  for (genvar g = 0; g < 2; g++) begin : g_satchk
    // R6
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_v && s1_sat[g]) |-> s1_prod[g] == {1'b0, {(PROD_W-1){1'b1}}});
  end
endmodule

// File: tb/cplx_mac_tb_top.sv
module cplx_mac_tb_top;
  logic        clk;
  logic        rst_n;
  logic        issue_valid;
  logic [31:0] op_a, op_b;
  logic [1:0]  acc_sel, mode;
  logic        frac;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [63:0] wr_data;
  logic [1:0]  rd_sel;
  logic [63:0] rd_data;
  logic [3:0]  ovf;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [63:0] exp_acc [4];
  logic [3:0]  exp_ovf;

  cplx_mac dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_a(op_a), .op_b(op_b),
    .acc_sel(acc_sel), .mode(mode), .frac(frac), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint lmul(input logic [15:0] x, input logic [15:0] y,
                                  input logic f, inout bit s);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    if (f) begin
      if (x == 16'h8000 && y == 16'h8000) begin
        p = 64'h7FFF_FFFF;
        s = 1;
      end else begin
        p = p * 2;
      end
    end
    return p;
  endfunction

  function automatic longint contrib(input logic [31:0] a, input logic [31:0] b,
                                     input logic [1:0] m, input logic f, output bit s);
    s = 0;
    case (m)
      2'd0: return lmul(a[31:16], b[31:16], f, s) + lmul(a[15:0], b[15:0], f, s);
      2'd1: return lmul(a[31:16], b[31:16], f, s) - lmul(a[15:0], b[15:0], f, s);
      2'd2: return lmul(a[31:16], b[15:0], f, s) + lmul(a[15:0], b[31:16], f, s);
      default: return -(lmul(a[31:16], b[31:16], f, s) + lmul(a[15:0], b[15:0], f, s));
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input logic [1:0] sel, input string tag);
    rd_sel = sel;
    #1;
    chk(rd_data === exp_acc[sel], tag, rd_data, exp_acc[sel]);
  endtask

  task automatic chk_ovf(input string tag);
    chk(ovf === exp_ovf, tag, {60'd0, ovf}, {60'd0, exp_ovf});
  endtask

  // called at a negedge; the op is sampled at the next posedge
  task automatic drive_op(input logic [1:0] sel, input logic [1:0] m, input logic f,
                          input logic [31:0] a, input logic [31:0] b);
    bit s;
    issue_valid = 1; acc_sel = sel; mode = m; frac = f; op_a = a; op_b = b;
    exp_acc[sel] = exp_acc[sel] + 64'(contrib(a, b, m, f, s));
    if (s) exp_ovf[sel] = 1'b1;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [63:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    exp_acc[sel] = d; exp_ovf[sel] = 1'b0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) chk_acc(2'(i), "R1 reset accumulator zero");
    chk_ovf("R1 reset flags clear");
  endtask

  task automatic t_host();
    host_wr(0, 64'h0123_4567_89AB_CDEF);
    host_wr(1, 64'hFFFF_FFFF_FFFF_FFF0);
    host_wr(2, 64'd0);
    host_wr(3, 64'h8000_0000_0000_0001);
    for (int i = 0; i < 4; i++) chk_acc(2'(i), "R1 host load and read");
  endtask

  task automatic t_modes();
    host_wr(0, 0);
    drive_op(0, 2'd0, 0, 32'h0003_FFFE, 32'h0005_0007);
    settle(); chk_acc(0, "R2 dot integer");
    drive_op(0, 2'd0, 0, 32'h7FFF_8001, 32'h7FFF_8001);
    settle(); chk_acc(0, "R2 dot extreme");
    host_wr(1, 64'd100);
    drive_op(1, 2'd1, 0, 32'h0010_0020, 32'h0003_0004);
    settle(); chk_acc(1, "R3 real part");
    drive_op(2, 2'd2, 0, 32'h0002_0003, 32'h0005_FFF9);
    settle(); chk_acc(2, "R4 cross");
    host_wr(3, 64'd1000);
    drive_op(3, 2'd3, 0, 32'h0011_0022, 32'h0003_FFFF);
    settle(); chk_acc(3, "R5 negated dot");
    chk_ovf("R2 integer leaves flags clear");
  endtask

  task automatic t_frac();
    host_wr(0, 0); host_wr(1, 0); host_wr(2, 0);
    drive_op(0, 2'd0, 1, 32'h4000_2000, 32'h4000_C000);
    settle(); chk_acc(0, "R6 fractional doubling");
    chk_ovf("R6 no flag without saturation");
    drive_op(1, 2'd0, 1, 32'h8000_0000, 32'h8000_0000);
    settle(); chk_acc(1, "R6 saturated product");
    chk(exp_acc[1] == 64'h7FFF_FFFF, "R6 model value", exp_acc[1], 64'h7FFF_FFFF);
    chk_ovf("R6 saturation flag set");
    drive_op(2, 2'd0, 0, 32'h8000_0000, 32'h8000_0000);
    settle(); chk_acc(2, "R6 integer most negative square");
    chk_ovf("R6 integer no flag");
    drive_op(1, 2'd2, 0, 32'h0001_0001, 32'h0001_0001);
    settle(); chk_ovf("R6 flag sticky");
    host_wr(1, 64'd5);
    settle(); chk_ovf("R6 host write clears flag");
  endtask

  task automatic t_latency();
    host_wr(2, 0);
    settle();
    drive_op(2, 2'd0, 0, 32'h0007_0000, 32'h0009_0000);
    rd_sel = 2; #1;
    chk(rd_data === 64'd0, "R7 not visible after edge k", rd_data, 64'd0);
    @(negedge clk); #1;
    chk(rd_data === 64'd0, "R7 not visible after edge k+1", rd_data, 64'd0);
    @(negedge clk); #1;
    chk(rd_data === 64'd63, "R7 visible after edge k+2", rd_data, 64'd63);
  endtask

  task automatic t_b2b();
    host_wr(0, 0); host_wr(1, 0);
    drive_op(0, 2'd0, 0, 32'h0001_0002, 32'h0003_0004);
    drive_op(0, 2'd1, 0, 32'h0005_0006, 32'h0007_0008);
    drive_op(0, 2'd2, 1, 32'h1000_2000, 32'h3000_4000);
    drive_op(0, 2'd3, 0, 32'h0009_000A, 32'h000B_000C);
    settle(); chk_acc(0, "R8 four back-to-back same accumulator");
    drive_op(0, 2'd0, 0, 32'h0100_0000, 32'h0100_0000);
    drive_op(1, 2'd0, 0, 32'h0200_0000, 32'h0010_0000);
    drive_op(0, 2'd2, 0, 32'h0003_0005, 32'h0007_000B);
    drive_op(1, 2'd1, 0, 32'h0004_0006, 32'h0002_0003);
    drive_op(1, 2'd0, 0, 32'hFFFF_FFFF, 32'h0001_0001);
    settle();
    chk_acc(0, "R8 interleaved accumulator 0");
    chk_acc(1, "R8 interleaved accumulator 1");
  endtask

  task automatic t_wrap();
    host_wr(3, 64'h7FFF_FFFF_FFFF_FFFF);
    drive_op(3, 2'd0, 0, 32'h0001_0000, 32'h0001_0000);
    settle(); chk_acc(3, "R9 positive wrap");
    chk(exp_acc[3] == 64'h8000_0000_0000_0000, "R9 model wrap", exp_acc[3], 64'h8000_0000_0000_0000);
    drive_op(3, 2'd3, 0, 32'h0000_0002, 32'h0000_0001);
    settle(); chk_acc(3, "R9 negative wrap");
    chk_ovf("R9 wrap raises no flag");
  endtask

  task automatic t_order();
    bit s;
    longint cy;
    host_wr(0, 64'd77);
    settle();
    // X at edge e-2 (fractional saturating), Y at e-1, host write at e
    issue_valid = 1; acc_sel = 0; mode = 2'd0; frac = 1; op_a = 32'h8000_0000; op_b = 32'h8000_0000;
    @(negedge clk);
    mode = 2'd0; frac = 0; op_a = 32'h0006_0000; op_b = 32'h0007_0000;
    cy = contrib(op_a, op_b, mode, frac, s);
    @(negedge clk);
    issue_valid = 0;
    wr_en = 1; wr_sel = 0; wr_data = 64'd1000;
    @(negedge clk);
    wr_en = 0;
    exp_acc[0] = 64'd1000 + 64'(cy);
    exp_ovf[0] = 1'b0;
    settle();
    chk_acc(0, "R10 write overrides same-edge op, later op adds on");
    chk_ovf("R10 overridden op flag dropped");
  endtask

  task automatic t_idle();
    host_wr(2, 64'h55);
    settle();
    issue_valid = 0; acc_sel = 2; mode = 2'd0; frac = 1; op_a = 32'h8000_8000; op_b = 32'h8000_8000;
    repeat (2) @(negedge clk);
    op_a = 32'h1234_5678; mode = 2'd3;
    settle();
    chk_acc(2, "R11 no issue leaves accumulator");
    chk_ovf("R11 no issue leaves flags");
  endtask

  initial begin
    rst_n = 0; issue_valid = 0; op_a = 0; op_b = 0; acc_sel = 0; mode = 0; frac = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    for (int i = 0; i < 4; i++) exp_acc[i] = 64'd0;
    exp_ovf = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host();
    t_modes();
    t_frac();
    t_latency();
    t_b2b();
    t_wrap();
    t_order();
    t_idle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule